// File: doc/BRIEF.md
# Addressed Command Target with Indexed Register Window

This block is the target side of an 8-bit shared peripheral bus on which several controllers sit, each known by a 3-bit number. The host frames every processor cycle with an active-low chip select, a read/write line and one address line. With the address line low, a write is a command byte. Its upper three bits name the controller and its lower five bits carry the operation. A target whose number matches becomes the selected one. Any other number deselects it. Only while selected does it accept address-high bytes into one of three parameter registers, and it returns them on reads. The command's operation field is loaded as the block's mode.

The block owns an interrupt flag that drives a shared, active-low, open-drain line. The flag is raised each time the selected target finishes handling a written byte, and again when the attached transfer engine reports the end of a transfer. It is acknowledged at the start of every address-low cycle. A mode enable bit gates both the interrupt and the transfer request. Reset clears that bit, so after reset the line is always released.

All bus inputs are sampled on the system clock. A written byte takes effect on the edge where chip select is seen released. The values it uses are the ones last held during the low phase.

Top module: `dbus_cmd_target`

## Requirements
- R1: After reset, `sel_active`, `irq_pull`, `dma_en` and `bus_doe` are 0 and all parameter registers read as zero on `prm_q`.
- R2: A written byte takes effect only on the clock edge at which `bus_cs_n` is first seen high after being low. The byte, address line and direction used are those sampled in the last low cycle, and a change of `bus_din` in the release cycle has no effect.
- R3: A write with `bus_a1`=0 whose data bits 7:5 equal `OWN_ID` selects the target and loads the mode from data bits 3:0: bit 0 enable, bit 1 transfer request, bits 3:2 register index. Data bit 4 is ignored.
- R4: A write with `bus_a1`=0 and any other number in bits 7:5 deselects the target and clears its byte counter. Address-high writes are then ignored and reads are not driven.
- R5: An address-high write while selected stores the byte in parameter register n, where n is the mode's register index. Register n appears on `prm_q[8n+7:8n]`. Each such write advances a 3-bit byte counter that saturates at 7 and is cleared by every command byte.
- R6: Register index 3 selects nothing: writes there leave all parameter registers unchanged, and reads return 0x00.
- R7: `bus_doe` is 1 only while the target is selected, `bus_cs_n` is low and `bus_rw` is 1. An address-low read returns {counter[2:0], 0, mode[3:0]}, and an address-high read returns the indexed register.
- R8: With the enable bit set, completing a matching command byte or a selected parameter write sets `irq_pull` (1 means the shared line is pulled low) from the next cycle on.
- R9: The clock edge that first sees `bus_cs_n` low with `bus_a1`=0, whether for a read or a write, clears the pending interrupt.
- R10: A one-cycle `xfer_done` pulse while selected and enabled sets `irq_pull`. While deselected it has no effect.
- R11: While the enable bit is clear or the target is deselected, `irq_pull` stays 0, a pending interrupt is dropped, and no completion sets it.
- R12: `dma_en` is 1 exactly when the target is selected and both the enable and transfer request bits are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs_n | input | 1 | Active-low cycle select from the host |
| bus_rw | input | 1 | 1 = host reads, 0 = host writes |
| bus_a1 | input | 1 | 0 = command/mode cycle, 1 = parameter cycle |
| bus_din | input | 8 | Byte written by the host |
| bus_dout | output | 8 | Byte returned on a read |
| bus_doe | output | 1 | Enables the target's data drivers |
| irq_pull | output | 1 | 1 pulls the shared active-low interrupt line down |
| xfer_done | input | 1 | One-cycle end-of-transfer pulse from the data mover |
| dma_en | output | 1 | Transfer request enable to the data mover |
| sel_active | output | 1 | Target currently selected |
| prm_q | output | 24 | Parameter registers, register n at bits 8n+7:8n |

## Verification
On every cycle, the assertions check several gating rules. The interrupt never shows without the enable bit. The transfer enable never shows without selection. The data drivers turn on only inside a selected read. Any address-low cycle start acknowledges a pending interrupt. The outputs are quiet right after reset. Some behaviours depend on byte values and on order, and only the bench scenarios can show them. These are ID matching and deselection, which register the index reaches, counter saturation, the read-back formats, the dead fourth index, and the fact that data changed in the release cycle is not captured.

// File: rtl/dbus_tgt_pkg.sv
package dbus_tgt_pkg;

    localparam int DATA_W  = 8;
    localparam int ID_W    = 3;
    localparam int SEL_W   = 2;
    localparam int CNT_W   = 3;
    localparam int NUM_PRM = 3;
    localparam int MODE_W  = 4;
    localparam int PRM_BUS_W = NUM_PRM * DATA_W;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // mode word: index in [3:2], transfer request in [1], enable in [0]
    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             dma_req;
        logic             enable;
    } mode_t;

    // one host cycle as seen during its low phase
    typedef struct packed {
        logic              a1;
        logic              rw;
        logic [DATA_W-1:0] data;
    } cycle_t;

    function automatic logic [ID_W-1:0] cmd_id(input logic [DATA_W-1:0] b);
        return b[DATA_W-1 -: ID_W];
    endfunction

    function automatic mode_t cmd_mode(input logic [DATA_W-1:0] b);
        return mode_t'(b[MODE_W-1:0]);
    endfunction

endpackage

// File: rtl/dbus_cycle_capture.sv
module dbus_cycle_capture
    import dbus_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_cs_n,
    input  logic              bus_rw,
    input  logic              bus_a1,
    input  logic [DATA_W-1:0] bus_din,
    output logic              cyc_start,
    output logic              cyc_done,
    output cycle_t            cyc_q
);

    logic cs_low_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_low_q <= 1'b0;
            cyc_q    <= '0;
        end else begin
            cs_low_q <= ~bus_cs_n;
            if (!bus_cs_n) begin
                cyc_q.a1   <= bus_a1;
                cyc_q.rw   <= bus_rw;
                cyc_q.data <= bus_din;
            end
        end
    end

    assign cyc_start = ~cs_low_q & ~bus_cs_n;
    assign cyc_done  = cs_low_q & bus_cs_n;

endmodule

// File: rtl/dbus_tgt_regs.sv
module dbus_tgt_regs
    import dbus_tgt_pkg::*;
#(
    parameter logic [ID_W-1:0] OWN_ID = 3'd5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cyc_done,
    input  cycle_t               cyc_q,
    input  logic                 bus_cs_n,
    input  logic                 bus_rw,
    input  logic                 bus_a1,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 rd_drive,
    output logic                 handled,
    output logic                 live_next,
    output logic                 sel_q,
    output mode_t                mode_q,
    output logic [PRM_BUS_W-1:0] prm_flat
);

    logic              cmd_wr;
    logic              cmd_hit;
    logic              prm_wr;
    logic              sel_d;
    mode_t             mode_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] prm_q [NUM_PRM];
    logic [DATA_W-1:0] prm_rd;

    assign cmd_wr  = cyc_done & ~cyc_q.a1 & ~cyc_q.rw;
    assign cmd_hit = cmd_wr & (cmd_id(cyc_q.data) == OWN_ID);
    assign prm_wr  = cyc_done & cyc_q.a1 & ~cyc_q.rw & sel_q;
    assign handled = cmd_hit | prm_wr;

    assign sel_d  = cmd_wr ? cmd_hit : sel_q;
    assign mode_d = cmd_hit ? cmd_mode(cyc_q.data) : mode_q;
    assign live_next = sel_d & mode_d.enable;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= 1'b0;
            mode_q <= '0;
            cnt_q  <= '0;
        end else begin
            sel_q  <= sel_d;
            mode_q <= mode_d;
            if (cmd_wr)
                cnt_q <= '0;
            else if (prm_wr && cnt_q != CNT_MAX)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    for (genvar i = 0; i < NUM_PRM; i++) begin : g_prm
        always_ff @(posedge clk) begin
            if (rst)
                prm_q[i] <= '0;
            else if (prm_wr && mode_q.sel == SEL_W'(i))
                prm_q[i] <= cyc_q.data;
        end
        assign prm_flat[i*DATA_W +: DATA_W] = prm_q[i];
    end

    always_comb begin
        prm_rd = '0;
        for (int i = 0; i < NUM_PRM; i++)
            if (mode_q.sel == SEL_W'(i))
                prm_rd = prm_q[i];
    end

    assign rd_data  = bus_a1 ? prm_rd : {cnt_q, 1'b0, mode_q};
    assign rd_drive = sel_q & ~bus_cs_n & bus_rw;

endmodule

// File: rtl/dbus_irq_latch.sv
module dbus_irq_latch (
    input  logic clk,
    input  logic rst,
    input  logic live_next,
    input  logic ack,
    input  logic raise,
    output logic irq_pull
);

    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= 1'b0;
        else if (!live_next)
            pend_q <= 1'b0;
        else if (ack)
            pend_q <= 1'b0;
        else if (raise)
            pend_q <= 1'b1;
    end

    assign irq_pull = pend_q;

endmodule

// File: rtl/dbus_cmd_target.sv
module dbus_cmd_target
    import dbus_tgt_pkg::*;
#(
    parameter logic [ID_W-1:0] OWN_ID = 3'd5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_cs_n,
    input  logic                 bus_rw,
    input  logic                 bus_a1,
    input  logic [DATA_W-1:0]    bus_din,
    output logic [DATA_W-1:0]    bus_dout,
    output logic                 bus_doe,
    output logic                 irq_pull,
    input  logic                 xfer_done,
    output logic                 dma_en,
    output logic                 sel_active,
    output logic [PRM_BUS_W-1:0] prm_q
);

    logic   cyc_start;
    logic   cyc_done;
    cycle_t cyc_q;
    logic   handled;
    logic   live_next;
    logic   sel_q;
    mode_t  mode_q;
    logic   irq_ack;
    logic   irq_raise;
    logic   mode_en_w;

    dbus_cycle_capture u_cap (
        .clk       (clk),
        .rst       (rst),
        .bus_cs_n  (bus_cs_n),
        .bus_rw    (bus_rw),
        .bus_a1    (bus_a1),
        .bus_din   (bus_din),
        .cyc_start (cyc_start),
        .cyc_done  (cyc_done),
        .cyc_q     (cyc_q)
    );

    dbus_tgt_regs #(.OWN_ID(OWN_ID)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cyc_done  (cyc_done),
        .cyc_q     (cyc_q),
        .bus_cs_n  (bus_cs_n),
        .bus_rw    (bus_rw),
        .bus_a1    (bus_a1),
        .rd_data   (bus_dout),
        .rd_drive  (bus_doe),
        .handled   (handled),
        .live_next (live_next),
        .sel_q     (sel_q),
        .mode_q    (mode_q),
        .prm_flat  (prm_q)
    );

    assign irq_ack   = cyc_start & ~bus_a1;
    assign irq_raise = handled | (xfer_done & sel_q);

    dbus_irq_latch u_irq (
        .clk       (clk),
        .rst       (rst),
        .live_next (live_next),
        .ack       (irq_ack),
        .raise     (irq_raise),
        .irq_pull  (irq_pull)
    );

    assign mode_en_w  = mode_q.enable;
    assign sel_active = sel_q;
    assign dma_en     = sel_q & mode_q.enable & mode_q.dma_req;

endmodule

// File: rtl/dbus_cmd_target_chk.sv
module dbus_cmd_target_chk (
    input logic clk,
    input logic rst,
    input logic bus_cs_n,
    input logic bus_rw,
    input logic bus_a1,
    input logic bus_doe,
    input logic irq_pull,
    input logic dma_en,
    input logic sel_active,
    input logic mode_en
);

    logic cs_hi_q;

    always_ff @(posedge clk) begin
        if (rst) cs_hi_q <= 1'b1;
        else     cs_hi_q <= bus_cs_n;
    end

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq_pull && !dma_en && !sel_active));

    a_r11_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
        irq_pull |-> (mode_en && sel_active));

    a_r12_dma_needs_select: assert property (@(posedge clk) disable iff (rst)
        dma_en |-> (sel_active && mode_en));

    a_r7_drive_window: assert property (@(posedge clk) disable iff (rst)
        bus_doe |-> (!bus_cs_n && bus_rw && sel_active));

    a_r9_low_cycle_acks: assert property (@(posedge clk) disable iff (rst)
        (cs_hi_q && !bus_cs_n && !bus_a1) |=> !irq_pull);

endmodule

bind dbus_cmd_target dbus_cmd_target_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_cs_n   (bus_cs_n),
    .bus_rw     (bus_rw),
    .bus_a1     (bus_a1),
    .bus_doe    (bus_doe),
    .irq_pull   (irq_pull),
    .dma_en     (dma_en),
    .sel_active (sel_active),
    .mode_en    (mode_en_w)
);

// File: tb/dbus_cmd_target_test.sv
module dbus_cmd_target_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_cs_n = 1'b1;
    logic        bus_rw = 1'b1;
    logic        bus_a1 = 1'b0;
    logic [7:0]  bus_din = 8'h00;
    logic [7:0]  bus_dout;
    logic        bus_doe;
    logic        irq_pull;
    logic        xfer_done = 1'b0;
    logic        dma_en;
    logic        sel_active;
    logic [23:0] prm_q;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    dbus_cmd_target #(.OWN_ID(3'd5)) uut (
        .clk(clk), .rst(rst), .bus_cs_n(bus_cs_n), .bus_rw(bus_rw),
        .bus_a1(bus_a1), .bus_din(bus_din), .bus_dout(bus_dout),
        .bus_doe(bus_doe), .irq_pull(irq_pull), .xfer_done(xfer_done),
        .dma_en(dma_en), .sel_active(sel_active), .prm_q(prm_q)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic a1, input logic [7:0] d);
        @(negedge clk); bus_a1 = a1; bus_rw = 1'b0; bus_din = d; bus_cs_n = 1'b1;
        @(negedge clk); bus_cs_n = 1'b0;
        @(negedge clk);
        @(negedge clk); bus_cs_n = 1'b1;
        @(negedge clk); bus_rw = 1'b1;
    endtask

    task automatic rd(input logic a1, output logic [7:0] d, output logic oe, output logic irq);
        @(negedge clk); bus_a1 = a1; bus_rw = 1'b1; bus_cs_n = 1'b1;
        @(negedge clk); bus_cs_n = 1'b0;
        @(negedge clk); d = bus_dout; oe = bus_doe; irq = irq_pull;
        @(negedge clk); bus_cs_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_done();
        @(negedge clk); xfer_done = 1'b1;
        @(negedge clk); xfer_done = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d; logic oe, irq;
        check("R1 sel", sel_active, 0);
        check("R1 irq", irq_pull, 0);
        check("R1 dma", dma_en, 0);
        check("R1 prm", prm_q, 0);
        rd(1'b0, d, oe, irq);
        check("R1 doe", oe, 0);
    endtask

    task automatic t_select();
        logic [7:0] d; logic oe, irq;
        wr(1'b0, 8'hB5);
        check("R3 selected", sel_active, 1);
        check("R8 irq after cmd", irq_pull, 1);
        rd(1'b0, d, oe, irq);
        check("R3 mode readback bit4 ignored", d, 8'h05);
        check("R7 doe on read", oe, 1);
        check("R9 read ack", irq, 0);
    endtask

    task automatic t_params();
        logic [7:0] d; logic oe, irq;
        wr(1'b0, 8'hA1);
        wr(1'b1, 8'h11);
        check("R5 reg0", prm_q[7:0], 8'h11);
        check("R8 irq after param", irq_pull, 1);
        wr(1'b0, 8'hA5);
        wr(1'b1, 8'h3C);
        check("R5 reg1", prm_q[15:8], 8'h3C);
        wr(1'b0, 8'hA9);
        wr(1'b1, 8'h77);
        check("R5 reg2", prm_q[23:16], 8'h77);
        rd(1'b1, d, oe, irq);
        check("R7 param read", d, 8'h77);
        check("R7 param read irq held", irq, 1);
        rd(1'b0, d, oe, irq);
        check("R7 R5 count and mode", d, 8'h29);
    endtask

    task automatic t_capture();
        wr(1'b0, 8'hA1);
        @(negedge clk); bus_a1 = 1'b1; bus_rw = 1'b0; bus_din = 8'h5A; bus_cs_n = 1'b1;
        @(negedge clk); bus_cs_n = 1'b0;
        @(negedge clk);
        check("R2 no update while low", prm_q[7:0], 8'h11);
        @(negedge clk); bus_cs_n = 1'b1; bus_din = 8'hFF;
        @(negedge clk); bus_rw = 1'b1;
        check("R2 latched low-phase byte", prm_q[7:0], 8'h5A);
    endtask

    task automatic t_unused();
        logic [7:0] d; logic oe, irq;
        wr(1'b0, 8'hAD);
        wr(1'b1, 8'hEE);
        check("R6 regs unchanged", prm_q, 24'h773C5A);
        rd(1'b1, d, oe, irq);
        check("R6 reads zero", d, 8'h00);
        check("R6 driven", oe, 1);
    endtask

    task automatic t_count();
        logic [7:0] d; logic oe, irq;
        wr(1'b0, 8'hA5);
        for (int i = 0; i < 9; i++) wr(1'b1, 8'(i));
        rd(1'b0, d, oe, irq);
        check("R5 count saturates", d, 8'hE5);
        check("R5 last param", prm_q[15:8], 8'h08);
    endtask

    task automatic t_deselect();
        logic [7:0] d; logic oe, irq;
        wr(1'b0, 8'h45);
        check("R4 deselected", sel_active, 0);
        check("R11 irq off when deselected", irq_pull, 0);
        wr(1'b1, 8'h99);
        check("R4 write ignored", prm_q[15:8], 8'h08);
        check("R4 no irq", irq_pull, 0);
        rd(1'b1, d, oe, irq);
        check("R4 no drive", oe, 0);
        wr(1'b0, 8'hA5);
        rd(1'b0, d, oe, irq);
        check("R4 count cleared", d, 8'h05);
    endtask

    task automatic t_xfer();
        logic [7:0] d; logic oe, irq;
        wr(1'b0, 8'hA5);
        rd(1'b0, d, oe, irq);
        check("R9 cleared before pulse", irq_pull, 0);
        pulse_done();
        check("R10 end of transfer irq", irq_pull, 1);
        wr(1'b0, 8'h45);
        pulse_done();
        check("R10 ignored when deselected", irq_pull, 0);
    endtask

    task automatic t_enable();
        wr(1'b0, 8'hA5);
        check("R8 irq set", irq_pull, 1);
        wr(1'b0, 8'hA6);
        check("R11 irq dropped", irq_pull, 0);
        check("R11 dma off", dma_en, 0);
        wr(1'b1, 8'h42);
        check("R11 param stored", prm_q[15:8], 8'h42);
        check("R11 no irq on param", irq_pull, 0);
        pulse_done();
        check("R11 no irq on done", irq_pull, 0);
    endtask

    task automatic t_dma();
        wr(1'b0, 8'hA7);
        check("R12 dma on", dma_en, 1);
        wr(1'b0, 8'hA5);
        check("R12 dma off no req", dma_en, 0);
        wr(1'b0, 8'hA7);
        wr(1'b0, 8'h47);
        check("R12 dma off deselected", dma_en, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_select();
        t_params();
        t_capture();
        t_unused();
        t_count();
        t_deselect();
        t_xfer();
        t_enable();
        t_dma();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule